// File: doc/BRIEF.md
# SPI Byte-Addressed Register Peripheral

This block lets an external SPI host read and write a bank of 16-bit registers that live in the surrounding logic. Every register appears to the host as two byte locations: the even byte address carries bits 7:0 and the odd one carries bits 15:8. The host sends 16-bit frames in SPI mode 3, most significant bit first. Each frame holds a direction bit, a 7-bit byte address and a data byte. A read request is answered on the data-out line during the frame that follows it, so a host can stream requests back to back and receive each answer one frame late.

Writes move one byte per frame. A low-byte write is held inside the block. The register is updated only when the matching high byte arrives, and then the whole 16-bit word is handed to the register file with a single-cycle commit strobe. The SPI pins are asynchronous to the system clock. They are brought in through flop synchronizers, and their edges are found by oversampling with the system clock.

Top module: `spi_regbank_periph`

## Requirements
- R1: The frame is 16 bits, SPI mode 3, MSB first. The block takes `mosi` on rising `sclk` edges. `miso` changes only after a falling `sclk` edge or after `cs_n` falls. The first falling edge of a frame leaves bit 15 in place.
- R2: Frame fields: bit 15 selects the direction (0 = read, 1 = write), bits 14:8 give the byte address, and bits 7:0 give the write data. In a read, bits 7:0 are ignored.
- R3: A read of either byte address of register k (byte addresses 2k and 2k+1) makes the next frame return the full 16-bit content of register k on `miso`.
- R4: During reset `rf_we` and `miso` are 0. Before any read request has been made, a frame returns 0x0000.
- R5: A frame that follows a write frame returns the current content of the register named by the most recent read request.
- R6: A low-byte write (even address) is buffered. A later high-byte write (odd address) to the same register causes one single-cycle `rf_we` pulse. During that pulse `rf_addr` holds the even byte address and `rf_wdata` holds {high byte, low byte}.
- R7: A low-byte write on its own commits nothing. A high-byte write with no buffered low byte, or with a buffered low byte for a different register, commits nothing and leaves every register unchanged.
- R8: Writes to read-only registers (parameter mask; by default registers 0 to 3, byte addresses 0x00 to 0x07) are ignored.
- R9: Reserved registers (parameter mask; by default registers 60 to 63, byte addresses 0x78 to 0x7F) read as 0x0000, and writes to them are ignored.
- R10: A frame in which `cs_n` rises after some number of rising `sclk` edges other than 16 is discarded. It does not change the buffered low byte, commits nothing, and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle high |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from the host |
| miso | output | 1 | SPI data to the host |
| rf_addr | output | 7 | Register-file byte address: the commit target during `rf_we`, otherwise the register last requested for read |
| rf_we | output | 1 | Single-cycle write commit strobe |
| rf_wdata | output | 16 | Committed 16-bit word |
| rf_rdata | input | 16 | Register-file read data for `rf_addr`, combinational |

## Verification
The assertions check on every cycle that a commit lasts exactly one cycle, that it targets an even byte address outside the read-only set, that it follows a decoded frame, and that it happens with chip select high. They also check that `miso` moves only after a falling `sclk` edge or a chip-select assertion. Only the bench scenarios can show that the data is right. They cover the one-frame read latency across every byte address, the answer after a write frame, the pairing of low and high bytes, the read-only and reserved registers, and the rejection of frames that are too short or too long.

// File: rtl/spi_rb_pkg.sv
// Shared widths and the command frame layout for the SPI register peripheral.
// Assumes fixed 16-bit frames with a 7-bit byte address field.
package spi_rb_pkg;
    localparam int FRAME_W   = 16;
    localparam int ADDR_W    = 7;
    localparam int BYTE_W    = 8;
    localparam int DATA_W    = 2 * BYTE_W;
    localparam int REG_IDX_W = ADDR_W - 1;
    localparam int REG_N     = 1 << REG_IDX_W;

    // Decoded layout of one host frame, MSB first on the wire.
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } cmd_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Brings sclk, cs_n and mosi into the clk domain through a flop chain and
// derives single-cycle edge strobes. Assumes clk runs at least several times
// faster than sclk, so that every sclk level lasts more than STAGES+1 clk cycles.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_low,
    output logic mosi_s
);
    localparam int NPIN = 3;
    // Bit order {mosi, cs_n, sclk}; idle bus has sclk high, cs_n high.
    localparam logic [NPIN-1:0] IDLE = 3'b011;

    logic [NPIN-1:0] pins_raw;
    logic [NPIN-1:0] pins_s;
    logic [NPIN-1:0] pins_q;

    assign pins_raw = {mosi_i, cs_n_i, sclk_i};

    genvar g;
    generate
        for (g = 0; g < NPIN; g++) begin : g_sync
            logic [STAGES-1:0] chain;
            // Shift one pin through its synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{IDLE[g]}};
                else        chain <= {chain[STAGES-2:0], pins_raw[g]};
            end
            assign pins_s[g] = chain[STAGES-1];
        end
    endgenerate

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= IDLE;
        else        pins_q <= pins_s;
    end

    assign sclk_rise = pins_s[0] & ~pins_q[0];
    assign sclk_fall = ~pins_s[0] & pins_q[0];
    assign cs_fall   = ~pins_s[1] & pins_q[1];
    assign cs_rise   = pins_s[1] & ~pins_q[1];
    assign cs_low    = ~pins_s[1];
    assign mosi_s    = pins_s[2];
endmodule

// File: rtl/spi_frame_shift.sv
// Serial engine. It shifts mosi in on rising sclk edges and shifts the reply
// word out on falling edges. The reply is loaded when chip select falls, and
// the first falling edge keeps bit 15. A frame is flagged valid only if
// exactly FRAME_W rising edges came before chip select rose.
module spi_frame_shift
    import spi_rb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               cs_fall,
    input  logic               cs_rise,
    input  logic               cs_low,
    input  logic               mosi_s,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               miso,
    output logic               frame_valid,
    output logic [FRAME_W-1:0] rx_word
);
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [FRAME_W-1:0] tx_sr;
    logic [FRAME_W-1:0] rx_sr;
    logic [CNT_W-1:0]   bit_cnt;

    // Load, shift in, shift out and count bits within one chip-select window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_cnt <= '0;
            miso    <= 1'b0;
        end else if (cs_fall) begin
            tx_sr   <= tx_word;
            miso    <= tx_word[FRAME_W-1];
            bit_cnt <= '0;
        end else if (cs_low) begin
            if (sclk_rise) begin
                rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
                if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
            end
            if (sclk_fall && (bit_cnt != '0)) begin
                tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
                miso  <= tx_sr[FRAME_W-2];
            end
        end
    end

    // Flag a complete frame on the chip-select release.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_valid <= 1'b0;
        else        frame_valid <= cs_rise && (bit_cnt == CNT_W'(FRAME_W));
    end

    assign rx_word = rx_sr;
endmodule

// File: rtl/spi_reg_cmd.sv
// Command decoder. Read requests record the target register, and the next
// frame's reply is built from it. Writes pass through a low-byte buffer and
// commit only on the matching high byte. Read-only and reserved registers are
// filtered by the parameter masks. Assumes rf_rdata follows rf_addr in the
// same cycle.
module spi_reg_cmd
    import spi_rb_pkg::*;
#(
    parameter logic [REG_N-1:0] RO_MASK   = '0,
    parameter logic [REG_N-1:0] RSVD_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] rx_word,
    input  logic [DATA_W-1:0]  rf_rdata,
    output logic [FRAME_W-1:0] tx_word,
    output logic [ADDR_W-1:0]  rf_addr,
    output logic               rf_we,
    output logic [DATA_W-1:0]  rf_wdata
);
    cmd_t                 cmd;
    logic [REG_IDX_W-1:0] cmd_idx;
    logic                 writable;

    logic [REG_IDX_W-1:0] rd_idx;
    logic                 rd_seen;
    logic [REG_IDX_W-1:0] low_idx;
    logic [BYTE_W-1:0]    low_byte;
    logic                 low_pend;
    logic [REG_IDX_W-1:0] wr_idx;
    logic                 commit_q;
    logic [DATA_W-1:0]    commit_data;

    assign cmd      = cmd_t'(rx_word);
    assign cmd_idx  = cmd.addr[ADDR_W-1:1];
    assign writable = !RO_MASK[cmd_idx] && !RSVD_MASK[cmd_idx];

    // Remember the register named by the most recent read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx  <= '0;
            rd_seen <= 1'b0;
        end else if (frame_valid && !cmd.wr) begin
            rd_idx  <= cmd_idx;
            rd_seen <= 1'b1;
        end
    end

    // Buffer low bytes and issue a one-cycle commit on the matching high byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_idx     <= '0;
            low_byte    <= '0;
            low_pend    <= 1'b0;
            wr_idx      <= '0;
            commit_q    <= 1'b0;
            commit_data <= '0;
        end else begin
            commit_q <= 1'b0;
            if (frame_valid && cmd.wr && writable) begin
                if (!cmd.addr[0]) begin
                    low_idx  <= cmd_idx;
                    low_byte <= cmd.data;
                    low_pend <= 1'b1;
                end else if (low_pend && (low_idx == cmd_idx)) begin
                    wr_idx      <= cmd_idx;
                    commit_data <= {cmd.data, low_byte};
                    commit_q    <= 1'b1;
                    low_pend    <= 1'b0;
                end
            end
        end
    end

    assign rf_we    = commit_q;
    assign rf_wdata = commit_data;
    assign rf_addr  = commit_q ? {wr_idx, 1'b0} : {rd_idx, 1'b0};
    assign tx_word  = (rd_seen && !RSVD_MASK[rd_idx]) ? rf_rdata : '0;
endmodule

// File: rtl/spi_regbank_periph.sv
// Top level of the SPI byte-addressed register peripheral: pin synchronizer,
// serial engine and command decoder. Assumes the register file outside the
// block answers rf_rdata combinationally for rf_addr.
module spi_regbank_periph
    import spi_rb_pkg::*;
#(
    parameter logic [63:0] RO_MASK     = 64'h0000_0000_0000_000F,
    parameter logic [63:0] RSVD_MASK   = 64'hF000_0000_0000_0000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);
    logic               sclk_rise;
    logic               sclk_fall;
    logic               cs_fall;
    logic               cs_rise;
    logic               cs_low;
    logic               mosi_s;
    logic               frame_valid;
    logic [FRAME_W-1:0] rx_word;
    logic [FRAME_W-1:0] tx_word;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .cs_n_i    (cs_n),
        .mosi_i    (mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .cs_low    (cs_low),
        .mosi_s    (mosi_s)
    );

    spi_frame_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .cs_fall     (cs_fall),
        .cs_rise     (cs_rise),
        .cs_low      (cs_low),
        .mosi_s      (mosi_s),
        .tx_word     (tx_word),
        .miso        (miso),
        .frame_valid (frame_valid),
        .rx_word     (rx_word)
    );

    spi_reg_cmd #(
        .RO_MASK   (RO_MASK[REG_N-1:0]),
        .RSVD_MASK (RSVD_MASK[REG_N-1:0])
    ) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .rx_word     (rx_word),
        .rf_rdata    (rf_rdata),
        .tx_word     (tx_word),
        .rf_addr     (rf_addr),
        .rf_we       (rf_we),
        .rf_wdata    (rf_wdata)
    );
endmodule

// File: rtl/spi_rb_checker.sv
// Protocol checker for spi_regbank_periph, attached with bind. It watches the
// commit strobe and the serial output timing.
module spi_rb_checker #(
    parameter logic [63:0] RO_MASK = 64'h0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rf_we,
    input logic [6:0] rf_addr,
    input logic       miso,
    input logic       sclk_fall,
    input logic       cs_fall,
    input logic       cs_low,
    input logic       frame_valid
);
    p_commit_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    p_commit_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !rf_addr[0]);

    p_commit_not_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !RO_MASK[rf_addr[6:1]]);

    p_commit_after_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(frame_valid));

    p_commit_cs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !cs_low);

    p_miso_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sclk_fall) && !$past(cs_fall)) |-> $stable(miso));
endmodule

bind spi_regbank_periph spi_rb_checker #(.RO_MASK(RO_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rf_we       (rf_we),
    .rf_addr     (rf_addr),
    .miso        (miso),
    .sclk_fall   (sclk_fall),
    .cs_fall     (cs_fall),
    .cs_low      (cs_low),
    .frame_valid (frame_valid)
);

// File: tb/tb_spi_regbank_periph.sv
module tb_spi_regbank_periph;
    localparam int HALF  = 6;
    localparam int STALL = 20;
    localparam int WDOG  = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [6:0]  rf_addr;
    logic        rf_we;
    logic [15:0] rf_wdata;
    logic [15:0] rf_rdata;

    logic [15:0] mem [64];
    logic [15:0] expv [64];
    int          we_cnt = 0;
    logic [6:0]  last_we_addr = '0;
    logic [15:0] last_we_data = '0;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 0;

    int          last_idx = 0;
    bit          last_valid = 0;
    bit          low_pend = 0;
    int          low_idx = 0;
    logic [7:0]  low_byte = '0;
    int          exp_we_cnt = 0;
    logic [6:0]  exp_we_addr = '0;
    logic [15:0] exp_we_data = '0;

    always #10 clk = ~clk;

    spi_regbank_periph dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .rf_rdata(rf_rdata)
    );

    assign rf_rdata = mem[rf_addr[6:1]];

    always @(posedge clk) begin
        if (rst_n && rf_we) begin
            mem[rf_addr[6:1]] <= rf_wdata;
            we_cnt            <= we_cnt + 1;
            last_we_addr      <= rf_addr;
            last_we_data      <= rf_wdata;
        end
    end

    function automatic bit is_ro(int i);
        return i < 4;
    endfunction

    function automatic bit is_rsvd(int i);
        return i >= 60;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic shift_frame(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
        rx = '0;
        @(posedge clk); #1 cs_n = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = tx[(15 - i) & 15];
            repeat (HALF) @(posedge clk);
            #1;
            rx = {rx[14:0], miso};
            sclk = 1'b1;
            repeat (HALF) @(posedge clk);
            #1;
        end
        cs_n = 1'b1;
        repeat (STALL) @(posedge clk);
        #1;
    endtask

    task automatic model_update(input logic [15:0] tx);
        logic [6:0] a;
        int         i;
        a = tx[14:8];
        i = int'(a[6:1]);
        if (!tx[15]) begin
            last_idx   = i;
            last_valid = 1;
        end else if (!is_ro(i) && !is_rsvd(i)) begin
            if (!a[0]) begin
                low_pend = 1;
                low_idx  = i;
                low_byte = tx[7:0];
            end else if (low_pend && low_idx == i) begin
                expv[i]     = {tx[7:0], low_byte};
                low_pend    = 0;
                exp_we_cnt++;
                exp_we_addr = {a[6:1], 1'b0};
                exp_we_data = expv[i];
            end
        end
    endtask

    // One full frame: check the reply, then apply the command to the model.
    task automatic frame(input logic [15:0] tx, input string tag);
        logic [15:0] rx;
        logic [15:0] exp_rx;
        exp_rx = (last_valid && !is_rsvd(last_idx)) ? expv[last_idx] : 16'h0000;
        shift_frame(tx, 16, rx);
        check(tag, {16'h0, rx}, {16'h0, exp_rx}, "miso word");
        model_update(tx);
        check(tag, we_cnt, exp_we_cnt, "commit count");
    endtask

    function automatic logic [15:0] rd(input logic [6:0] a);
        return {1'b0, a, 8'h5A};
    endfunction

    function automatic logic [15:0] wr(input logic [6:0] a, input logic [7:0] d);
        return {1'b1, a, d};
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]  = 16'(i * 16'h0137) ^ 16'hA55A;
            expv[i] = 16'(i * 16'h0137) ^ 16'hA55A;
        end
    end

    initial begin
        logic [15:0] rx;
        repeat (5) @(posedge clk);
        #1;
        // R4: reset state of the outputs
        check("R4", {31'h0, rf_we}, 32'h0, "rf_we in reset");
        check("R4", {31'h0, miso}, 32'h0, "miso in reset");
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;

        frame(rd(7'h0A), "R4");      // first frame returns zero
        frame(rd(7'h0B), "R1");      // reply for register 5 via even address
        frame(rd(7'h14), "R3");      // reply for register 5 via odd address

        // R3 / R9: chained sweep of every byte address
        for (int a = 0; a < 128; a++) begin
            frame(rd(7'(a)), (last_valid && is_rsvd(last_idx)) ? "R9" : "R3");
        end
        frame(rd(7'h14), "R9");

        // R5 / R6: low then high write with a read of the same register pending
        frame(wr(7'h14, 8'h3C), "R5");
        frame(wr(7'h15, 8'hC8), "R5");
        check("R2", {25'h0, last_we_addr}, {25'h0, exp_we_addr}, "commit address");
        check("R6", {16'h0, last_we_data}, {16'h0, 16'hC83C}, "commit data");
        frame(rd(7'h00), "R5");

        // R7: unpaired bytes
        frame(wr(7'h16, 8'h11), "R7");
        frame(rd(7'h16), "R7");
        frame(wr(7'h19, 8'h22), "R7");
        frame(wr(7'h1A, 8'h33), "R7");
        frame(wr(7'h1D, 8'h44), "R7");
        frame(rd(7'h18), "R7");
        frame(rd(7'h1C), "R7");
        frame(rd(7'h1A), "R7");

        // R8: read-only register
        frame(wr(7'h04, 8'h55), "R8");
        frame(wr(7'h05, 8'h66), "R8");
        frame(rd(7'h04), "R8");
        frame(rd(7'h05), "R8");

        // R9: reserved register
        frame(wr(7'h7A, 8'h77), "R9");
        frame(wr(7'h7B, 8'h78), "R9");
        frame(rd(7'h7A), "R9");
        frame(rd(7'h00), "R9");

        // R10: short and long frames are discarded
        frame(wr(7'h28, 8'h99), "R10");
        shift_frame(wr(7'h29, 8'hAA), 15, rx);
        check("R10", we_cnt, exp_we_cnt, "commit after 15-bit frame");
        shift_frame(wr(7'h29, 8'hAB), 17, rx);
        check("R10", we_cnt, exp_we_cnt, "commit after 17-bit frame");
        frame(wr(7'h29, 8'hAA), "R10");
        frame(rd(7'h28), "R10");
        frame(rd(7'h29), "R10");

        // R6 / R8 / R9: write sweep over all registers, then read back
        for (int i = 0; i < 64; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h0B1D) ^ 16'h3C96;
            frame(wr(7'(2 * i), v[7:0]), "R6");
            frame(wr(7'(2 * i + 1), v[15:8]), "R6");
        end
        for (int i = 0; i < 64; i++) begin
            frame(rd(7'(2 * i + (i & 1))), "R3");
        end
        frame(rd(7'h00), "R3");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule